// File: doc/BRIEF.md
# Instruction Length and Jump Target Checker

This front-end block takes a fetched instruction word along with the address it was fetched from. It sorts the word into short (16-bit) or full (32-bit) form and produces the address of the instruction that follows in sequence. When a direct jump is flagged, it adds the supplied immediate to the fetch address. It then decides whether the resulting target is aligned well enough for the current configuration.

The outcome is registered one cycle after a valid input:

- **Illegal instruction:** a short-form word was seen while short instructions are disabled.
- **Misaligned fetch:** the jump target is misaligned. The fetch address of the jump is reported as the faulting address.
- **Jump taken:** the target is returned, with a link value equal to the sequential successor address. The link value has a write enable that is suppressed for destination register 0.

The enable for short instructions decides both the length legality and the alignment rule. With short instructions disabled, targets must be 4-byte aligned. With them enabled, targets only need to be 2-byte aligned.

Top module: `insn_len_jchk`

## Requirements
- R1: `insn_short` is 1 exactly when bits [1:0] of the captured instruction are anything other than 2'b11.
- R2: `seq_pc` equals the captured `fetch_pc` plus 2 for a short instruction and plus 4 for a full one, modulo 2^XLEN.
- R3: A short instruction with `short_en` = 0 raises `illegal`. In that case `misaligned`, `jump_taken` and `link_we` are all 0, even when `is_jump` = 1.
- R4: For a legal jump (`is_jump` = 1) with an aligned target, `jump_taken` is 1 and `jump_target` equals `fetch_pc + jump_imm`, modulo 2^XLEN.
- R5: With `short_en` = 0, a legal jump whose target has bits [1:0] nonzero raises `misaligned` instead of `jump_taken`. `bad_addr` then equals the jump's own `fetch_pc`.
- R6: With `short_en` = 1, a jump target is misaligned only when its bit 0 is 1. A target with bits [1:0] = 2'b10 is taken.
- R7: `link_data` equals `seq_pc` on a taken jump. `link_we` is 1 exactly when `jump_taken` is 1 and `rd_idx` is not 0.
- R8: Outputs appear on the first rising clock edge after an input is presented with `in_valid` = 1. `out_valid` follows `in_valid` by one cycle. While `out_valid` is 0, `illegal`, `misaligned`, `jump_taken` and `link_we` are 0.
- R9: At most one of `illegal`, `misaligned` and `jump_taken` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input fields are valid this cycle |
| insn | input | 32 | Fetched instruction word |
| fetch_pc | input | XLEN | Address of the instruction |
| short_en | input | 1 | Short (16-bit) instructions enabled |
| is_jump | input | 1 | Instruction is a direct jump |
| jump_imm | input | XLEN | Decoded jump offset |
| rd_idx | input | 5 | Destination register index of the jump |
| out_valid | output | 1 | Registered result valid |
| insn_short | output | 1 | Instruction is 16-bit |
| seq_pc | output | XLEN | Sequential successor address |
| jump_target | output | XLEN | Computed jump target |
| jump_taken | output | 1 | Jump legal and aligned |
| link_data | output | XLEN | Value for the destination register |
| link_we | output | 1 | Link write enable |
| illegal | output | 1 | Illegal-instruction flag |
| misaligned | output | 1 | Misaligned-target flag |
| bad_addr | output | XLEN | Faulting address (jump's fetch address) |

## Verification
The bench sweeps every combination of these inputs:

- all four values of the two length bits, which separates short from full words;
- both settings of the short enable, which separates illegal from legal short words and the 4-byte from the 2-byte alignment rule;
- jump and non-jump;
- offsets from -4 to +3, which produce targets ending in each of the four low-bit patterns;
- destination 0 against a nonzero destination;
- fetch addresses that are 4-aligned, only 2-aligned, and at the top of the address space, where the successor and target addresses wrap.

Idle cycles between results confirm that no flag is raised without valid input.

// File: rtl/ilj_pkg.sv
package ilj_pkg;
  localparam int          ILEN          = 32;
  localparam int          RIDX_W        = 5;
  localparam logic [1:0]  FULL_LEN_CODE = 2'b11;
  localparam int          SHORT_BYTES   = 2;
  localparam int          FULL_BYTES    = 4;

  typedef struct packed {
    logic illegal;
    logic misal;
    logic taken;
    logic link_we;
  } ilj_flags_t;
endpackage

// File: rtl/ilj_len_class.sv
module ilj_len_class
  import ilj_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]      len_bits,
  input  logic [XLEN-1:0] pc,
  output logic            is_short,
  output logic [XLEN-1:0] succ_pc
);
  localparam logic [XLEN-1:0] STEP_S = XLEN'(SHORT_BYTES);
  localparam logic [XLEN-1:0] STEP_F = XLEN'(FULL_BYTES);

  always_comb begin
    is_short = (len_bits != FULL_LEN_CODE);
    succ_pc  = pc + (is_short ? STEP_S : STEP_F);
  end
endmodule

// File: rtl/ilj_jump_chk.sv
module ilj_jump_chk #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] imm,
  input  logic            short_en,
  output logic [XLEN-1:0] target,
  output logic            unaligned
);
  always_comb begin
    target = pc + imm;
    // short instructions enabled: halfword granularity; otherwise word
    if (short_en) unaligned = target[0];
    else          unaligned = |target[1:0];
  end
endmodule

// File: rtl/insn_len_jchk.sv
module insn_len_jchk
  import ilj_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ILEN-1:0]   insn,
  input  logic [XLEN-1:0]   fetch_pc,
  input  logic              short_en,
  input  logic              is_jump,
  input  logic [XLEN-1:0]   jump_imm,
  input  logic [RIDX_W-1:0] rd_idx,
  output logic              out_valid,
  output logic              insn_short,
  output logic [XLEN-1:0]   seq_pc,
  output logic [XLEN-1:0]   jump_target,
  output logic              jump_taken,
  output logic [XLEN-1:0]   link_data,
  output logic              link_we,
  output logic              illegal,
  output logic              misaligned,
  output logic [XLEN-1:0]   bad_addr
);
  logic            short_c;
  logic [XLEN-1:0] succ_c;
  logic [XLEN-1:0] tgt_c;
  logic            unal_c;
  ilj_flags_t      flags_c;

  ilj_len_class #(.XLEN(XLEN)) u_len (
    .len_bits (insn[1:0]),
    .pc       (fetch_pc),
    .is_short (short_c),
    .succ_pc  (succ_c)
  );

  ilj_jump_chk #(.XLEN(XLEN)) u_jchk (
    .pc        (fetch_pc),
    .imm       (jump_imm),
    .short_en  (short_en),
    .target    (tgt_c),
    .unaligned (unal_c)
  );

  // outcome priority: illegal length, then misalignment, then taken jump
  always_comb begin
    flags_c.illegal = short_c & ~short_en;
    flags_c.misal   = is_jump & ~flags_c.illegal & unal_c;
    flags_c.taken   = is_jump & ~flags_c.illegal & ~unal_c;
    flags_c.link_we = flags_c.taken & (rd_idx != '0);
  end

  // state
  logic            vld_q,   vld_d;
  ilj_flags_t      flg_q,   flg_d;
  logic            short_q, short_d;
  logic [XLEN-1:0] succ_q,  succ_d;
  logic [XLEN-1:0] tgt_q,   tgt_d;
  logic [XLEN-1:0] bad_q,   bad_d;

  always_comb begin
    vld_d   = in_valid;
    flg_d   = in_valid ? flags_c : '0;
    short_d = short_q;
    succ_d  = succ_q;
    tgt_d   = tgt_q;
    bad_d   = bad_q;
    if (in_valid) begin
      short_d = short_c;
      succ_d  = succ_c;
      tgt_d   = tgt_c;
      bad_d   = flags_c.misal ? fetch_pc : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      flg_q   <= '0;
      short_q <= 1'b0;
      succ_q  <= '0;
      tgt_q   <= '0;
      bad_q   <= '0;
    end else begin
      vld_q   <= vld_d;
      flg_q   <= flg_d;
      short_q <= short_d;
      succ_q  <= succ_d;
      tgt_q   <= tgt_d;
      bad_q   <= bad_d;
    end
  end

  assign out_valid   = vld_q;
  assign insn_short  = short_q;
  assign seq_pc      = succ_q;
  assign jump_target = tgt_q;
  assign jump_taken  = flg_q.taken;
  assign link_data   = succ_q;
  assign link_we     = flg_q.link_we;
  assign illegal     = flg_q.illegal;
  assign misaligned  = flg_q.misal;
  assign bad_addr    = bad_q;

  // R9
  excl_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal, misaligned, jump_taken}));

  // R8
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(illegal || misaligned || jump_taken || link_we));

  // R7
  link_needs_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> jump_taken);

  // R3
  illegal_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> insn_short);

  // R5
  bad_addr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_jump && !short_en && (insn[1:0] == FULL_LEN_CODE)
     && ((fetch_pc[1:0] + jump_imm[1:0]) != 2'b00))
    |=> (misaligned && bad_addr == $past(fetch_pc)));
endmodule

// File: tb/test_insn_len_jchk.sv
`timescale 1ns/1ps
module test_insn_len_jchk;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [31:0]     insn;
  logic [XLEN-1:0] fetch_pc;
  logic            short_en;
  logic            is_jump;
  logic [XLEN-1:0] jump_imm;
  logic [4:0]      rd_idx;
  logic            out_valid, insn_short, jump_taken, link_we, illegal, misaligned;
  logic [XLEN-1:0] seq_pc, jump_target, link_data, bad_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  insn_len_jchk #(.XLEN(XLEN)) i_insn_len_jchk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .fetch_pc(fetch_pc), .short_en(short_en), .is_jump(is_jump),
    .jump_imm(jump_imm), .rd_idx(rd_idx), .out_valid(out_valid),
    .insn_short(insn_short), .seq_pc(seq_pc), .jump_target(jump_target),
    .jump_taken(jump_taken), .link_data(link_data), .link_we(link_we),
    .illegal(illegal), .misaligned(misaligned), .bad_addr(bad_addr)
  );

  task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [XLEN-1:0] pcs [3];
    pcs[0] = 32'h0000_1000;
    pcs[1] = 32'h0000_2002;
    pcs[2] = 32'hFFFF_FFFE;
    rst_n = 1'b0; in_valid = 1'b0; insn = '0; fetch_pc = '0;
    short_en = 1'b0; is_jump = 1'b0; jump_imm = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset out_valid", out_valid, 0);
    chk("R8 reset flags", {illegal, misaligned, jump_taken, link_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle after reset", {out_valid, illegal, misaligned, jump_taken, link_we}, 0);

    for (int p = 0; p < 3; p++)
    for (int b = 0; b < 4; b++)
    for (int c = 0; c < 2; c++)
    for (int j = 0; j < 2; j++)
    for (int k = 0; k < 8; k++)
    for (int r = 0; r < 2; r++) begin
      logic            e_short, e_ill, e_unal, e_mis, e_tk, e_lwe;
      logic [XLEN-1:0] e_seq, e_tgt;
      fetch_pc = pcs[p];
      insn     = {30'h15A5_A5A5, 2'(b)};
      short_en = c[0];
      is_jump  = j[0];
      jump_imm = XLEN'(k - 4);
      rd_idx   = (r == 0) ? 5'd0 : 5'd5;
      in_valid = 1'b1;
      e_short = (b != 3);
      e_seq   = fetch_pc + (e_short ? 32'd2 : 32'd4);
      e_ill   = e_short && (c == 0);
      e_tgt   = fetch_pc + jump_imm;
      e_unal  = (c == 1) ? e_tgt[0] : (e_tgt[1:0] != 2'b00);
      e_mis   = (j == 1) && !e_ill && e_unal;
      e_tk    = (j == 1) && !e_ill && !e_unal;
      e_lwe   = e_tk && (r != 0);
      @(negedge clk);
      chk("R8 out_valid", out_valid, 1);
      chk("R1 insn_short", insn_short, e_short);
      chk("R2 seq_pc", seq_pc, e_seq);
      chk("R3 illegal", illegal, e_ill);
      chk(c ? "R6 misaligned" : "R5 misaligned", misaligned, e_mis);
      chk("R4 jump_taken", jump_taken, e_tk);
      chk("R9 exclusive", 32'(illegal) + 32'(misaligned) + 32'(jump_taken) <= 1, 1);
      if (j == 1) chk("R4 jump_target", jump_target, e_tgt);
      if (e_mis)  chk("R5 bad_addr", bad_addr, fetch_pc);
      if (e_tk)   chk("R7 link_data", link_data, e_seq);
      chk("R7 link_we", link_we, e_lwe);
      if (k == 7) begin
        in_valid = 1'b0;
        @(negedge clk);
        chk("R8 idle out_valid", out_valid, 0);
        chk("R8 idle flags", {illegal, misaligned, jump_taken, link_we}, 0);
      end
    end
    done = 1'b1;
    finish_run();
  end
endmodule